// File: doc/BRIEF.md
# Vertical Sync Pulse Generator

This block produces the vertical synchronisation pulse of a display controller that can drive a CRT monitor, an active-matrix panel or a passive LCD panel. The frame timing core supplies a one-cycle line strobe and, on the strobe of the first line of the vertical non-display period, a non-display start flag. The block counts lines from that point and places a pulse of programmable width at a programmable line offset inside the non-display period.

Two outputs are produced: a CRT vertical sync and a panel frame pulse. Each has its own polarity bit. The meaning of the panel polarity bit depends on the panel type, because the two panel types define it in opposite ways. In passive-panel mode the programmed offset and width do not apply to the panel output. It instead carries a one-line frame pulse on the first non-display line. All settings are latched only at a frame boundary. A sticky flag reports settings whose pulse does not fit inside the non-display period. Where that happens, the pulse is cut off at the end of the period.

Top module: `vsync_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the line counter returns to idle, `fit_err_o` becomes 0, and both `crt_vsync_o` and `panel_frame_o` become 1. The value 1 is the inactive level for the cleared settings.
- R2: A frame boundary is a clock edge at which `line_stb_i` and `vnd_start_i` are both 1. At a boundary, all setting inputs are captured and line index 0 begins. A change to any setting input at any other time has no effect on the outputs until the next boundary.
- R3: Line index 0 is the first non-display line. The CRT pulse begins on line index `sync_start_i + 1`, so the 6-bit field gives a delay of 1 to 64 lines.
- R4: The CRT pulse lasts `sync_width_i + 1` lines, so the 3-bit field gives 1 to 8 lines.
- R5: With `crt_pol_i` = 1 the CRT pulse is active high. With 0 it is active low. Outside the pulse the output rests at the opposite level.
- R6: With `passive_i` = 0, the panel frame pulse has the same timing as the CRT pulse. It is active high when `frame_pol_i` = 1 and active low when `frame_pol_i` = 0.
- R7: With `passive_i` = 1, the panel frame pulse is active on line index 0 only, regardless of `sync_start_i` and `sync_width_i`. It is active low when `frame_pol_i` = 1 and active high when `frame_pol_i` = 0.
- R8: The non-display period covers line indices 0 to `nd_lines_i`. No pulse is active outside it, and a pulse that would run past its last line is cut off there.
- R9: At a boundary, `fit_err_o` is set in the same edge if `(sync_start_i + 1) + (sync_width_i + 1) > nd_lines_i + 1`. Once set, it stays 1 until reset.
- R10: `crt_vsync_o` and `panel_frame_o` are registered. They show the state of a line one clock after the edge that samples that line's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_stb_i | input | 1 | One-cycle strobe at the start of every line |
| vnd_start_i | input | 1 | Marks the strobe of the first vertical non-display line |
| nd_lines_i | input | 6 | Non-display length minus one, in lines |
| sync_start_i | input | 6 | Pulse delay minus one, in lines |
| sync_width_i | input | 3 | Pulse width minus one, in lines |
| crt_pol_i | input | 1 | CRT sync polarity (1 = active high) |
| frame_pol_i | input | 1 | Panel frame polarity bit (meaning set by panel type) |
| passive_i | input | 1 | 1 = passive panel, 0 = active-matrix panel |
| crt_vsync_o | output | 1 | CRT vertical sync |
| panel_frame_o | output | 1 | Panel frame pulse |
| fit_err_o | output | 1 | Sticky flag for a pulse that does not fit |

## Verification
The hardest case to reach from the ports is a setting change that lands in the middle of a running non-display period. This case must leave the pulse and the idle levels untouched. To reach it, every stimulus frame inverts all setting inputs halfway through its non-display lines and restores them before the next boundary. The truncation case is also hard to reach. It is driven with a short non-display period, and with the largest start value, whose pulse lies wholly outside any legal period.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic {
        PNL_MATRIX  = 1'b0,
        PNL_PASSIVE = 1'b1
    } panel_kind_e;

    // Output level for a pulse given whether it is active and its active level.
    function automatic logic drive_level(input logic active, input logic act_lvl);
        return active ? act_lvl : ~act_lvl;
    endfunction

    // Active level of the panel frame pulse; passive panels read the bit inverted.
    function automatic logic panel_act_level(input panel_kind_e kind, input logic pol);
        return (kind == PNL_PASSIVE) ? ~pol : pol;
    endfunction

endpackage

// File: rtl/vsg_cfg_shadow.sv
module vsg_cfg_shadow
    import vsg_pkg::*;
#(
    parameter int START_W = 6,
    parameter int WIDTH_W = 3,
    parameter int ND_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [ND_W-1:0]    nd_i,
    input  logic [START_W-1:0] start_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic               crt_pol_i,
    input  logic               frame_pol_i,
    input  logic               passive_i,
    output logic [ND_W-1:0]    nd_o,
    output logic [START_W-1:0] start_o,
    output logic [WIDTH_W-1:0] width_o,
    output logic               crt_pol_o,
    output logic               frame_pol_o,
    output panel_kind_e        kind_o,
    output logic               err_o
);

    localparam int SUM_W = ((START_W > ND_W) ? START_W : ND_W) + 2;

    typedef struct packed {
        logic [ND_W-1:0]    nd;
        logic [START_W-1:0] start;
        logic [WIDTH_W-1:0] width;
        logic               cpol;
        logic               fpol;
        panel_kind_e        kind;
        logic               err;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic [SUM_W-1:0] last_pulse_line;

    always_comb begin
        sh_d = sh_q;
        last_pulse_line = SUM_W'(start_i) + SUM_W'(width_i) + SUM_W'(1);
        if (load_i) begin
            sh_d.nd    = nd_i;
            sh_d.start = start_i;
            sh_d.width = width_i;
            sh_d.cpol  = crt_pol_i;
            sh_d.fpol  = frame_pol_i;
            sh_d.kind  = panel_kind_e'(passive_i);
            if (last_pulse_line > SUM_W'(nd_i)) begin
                sh_d.err = 1'b1;
            end
        end
        if (!rst_n) begin
            sh_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign nd_o        = sh_q.nd;
    assign start_o     = sh_q.start;
    assign width_o     = sh_q.width;
    assign crt_pol_o   = sh_q.cpol;
    assign frame_pol_o = sh_q.fpol;
    assign kind_o      = sh_q.kind;
    assign err_o       = sh_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.err |=> sh_q.err); // R9

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable({sh_q.nd, sh_q.start, sh_q.width, sh_q.cpol, sh_q.fpol, sh_q.kind})); // R2

endmodule

// File: rtl/vsg_line_ctr.sv
module vsg_line_ctr #(
    parameter int ND_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_stb_i,
    input  logic            restart_i,
    input  logic [ND_W-1:0] last_i,
    output logic [ND_W-1:0] cnt_o,
    output logic            in_nd_o
);

    typedef struct packed {
        logic [ND_W-1:0] cnt;
        logic            in_nd;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_stb_i) begin
            if (restart_i) begin
                st_d.cnt   = '0;
                st_d.in_nd = 1'b1;
            end else if (st_q.in_nd) begin
                if (st_q.cnt == last_i) begin
                    st_d.in_nd = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign in_nd_o = st_q.in_nd;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_nd |-> (st_q.cnt <= last_i)); // R8

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb_i && restart_i) |=> (st_q.in_nd && st_q.cnt == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb_i |=> ($stable(st_q.cnt) && $stable(st_q.in_nd))); // R2

endmodule

// File: rtl/vsg_pulse_window.sv
module vsg_pulse_window
    import vsg_pkg::*;
#(
    parameter int START_W = 6,
    parameter int WIDTH_W = 3,
    parameter int ND_W    = 6
) (
    input  logic [ND_W-1:0]    cnt_i,
    input  logic               in_nd_i,
    input  logic [START_W-1:0] start_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  panel_kind_e        kind_i,
    output logic               crt_act_o,
    output logic               panel_act_o
);

    localparam int CMP_W = ((START_W > ND_W) ? START_W : ND_W) + 2;

    logic [CMP_W-1:0] line_w;
    logic [CMP_W-1:0] first_w;
    logic [CMP_W-1:0] last_w;
    logic             prog_act;
    logic             auto_act;

    always_comb begin
        line_w   = CMP_W'(cnt_i);
        first_w  = CMP_W'(start_i) + CMP_W'(1);
        last_w   = first_w + CMP_W'(width_i);
        prog_act = in_nd_i && (line_w >= first_w) && (line_w <= last_w);
        auto_act = in_nd_i && (cnt_i == '0);
        crt_act_o   = prog_act;
        panel_act_o = (kind_i == PNL_PASSIVE) ? auto_act : prog_act;
    end

endmodule

// File: rtl/vsync_pulse_gen.sv
module vsync_pulse_gen
    import vsg_pkg::*;
#(
    parameter int START_W = 6,
    parameter int WIDTH_W = 3,
    parameter int ND_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_stb_i,
    input  logic               vnd_start_i,
    input  logic [ND_W-1:0]    nd_lines_i,
    input  logic [START_W-1:0] sync_start_i,
    input  logic [WIDTH_W-1:0] sync_width_i,
    input  logic               crt_pol_i,
    input  logic               frame_pol_i,
    input  logic               passive_i,
    output logic               crt_vsync_o,
    output logic               panel_frame_o,
    output logic               fit_err_o
);

    typedef struct packed {
        logic crt;
        logic pnl;
    } out_t;

    logic               boundary_w;
    logic [ND_W-1:0]    sh_nd_w;
    logic [START_W-1:0] sh_start_w;
    logic [WIDTH_W-1:0] sh_width_w;
    logic               sh_cpol_w;
    logic               sh_fpol_w;
    panel_kind_e        sh_kind_w;
    logic [ND_W-1:0]    cnt_w;
    logic               in_nd_w;
    logic               crt_act_w;
    logic               pnl_act_w;
    out_t               out_d, out_q;

    assign boundary_w = line_stb_i && vnd_start_i;

    vsg_cfg_shadow #(
        .START_W (START_W),
        .WIDTH_W (WIDTH_W),
        .ND_W    (ND_W)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (boundary_w),
        .nd_i        (nd_lines_i),
        .start_i     (sync_start_i),
        .width_i     (sync_width_i),
        .crt_pol_i   (crt_pol_i),
        .frame_pol_i (frame_pol_i),
        .passive_i   (passive_i),
        .nd_o        (sh_nd_w),
        .start_o     (sh_start_w),
        .width_o     (sh_width_w),
        .crt_pol_o   (sh_cpol_w),
        .frame_pol_o (sh_fpol_w),
        .kind_o      (sh_kind_w),
        .err_o       (fit_err_o)
    );

    vsg_line_ctr #(
        .ND_W (ND_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb_i (line_stb_i),
        .restart_i  (vnd_start_i),
        .last_i     (sh_nd_w),
        .cnt_o      (cnt_w),
        .in_nd_o    (in_nd_w)
    );

    vsg_pulse_window #(
        .START_W (START_W),
        .WIDTH_W (WIDTH_W),
        .ND_W    (ND_W)
    ) u_win (
        .cnt_i       (cnt_w),
        .in_nd_i     (in_nd_w),
        .start_i     (sh_start_w),
        .width_i     (sh_width_w),
        .kind_i      (sh_kind_w),
        .crt_act_o   (crt_act_w),
        .panel_act_o (pnl_act_w)
    );

    always_comb begin
        out_d.crt = drive_level(crt_act_w, sh_cpol_w);
        out_d.pnl = drive_level(pnl_act_w, panel_act_level(sh_kind_w, sh_fpol_w));
        if (!rst_n) begin
            out_d.crt = drive_level(1'b0, 1'b0);
            out_d.pnl = drive_level(1'b0, panel_act_level(PNL_MATRIX, 1'b0));
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign crt_vsync_o   = out_q.crt;
    assign panel_frame_o = out_q.pnl;

    AST_CRT_IN_ND: assert property (@(posedge clk) disable iff (!rst_n)
        crt_act_w |-> in_nd_w); // R8

    AST_CRT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        crt_act_w |=> (crt_vsync_o == $past(sh_cpol_w))); // R5

    AST_PASSIVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_kind_w == PNL_PASSIVE && pnl_act_w) |-> (in_nd_w && cnt_w == '0)); // R7

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (crt_vsync_o && panel_frame_o && !fit_err_o)); // R1

endmodule

// File: tb/vsync_pulse_gen_tb_top.sv
module vsync_pulse_gen_tb_top;

    localparam int LINE_CYC = 3;
    localparam int DISP     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb_i = 1'b0;
    logic       vnd_start_i = 1'b0;
    logic [5:0] nd_lines_i = '0;
    logic [5:0] sync_start_i = '0;
    logic [2:0] sync_width_i = '0;
    logic       crt_pol_i = 1'b0;
    logic       frame_pol_i = 1'b0;
    logic       passive_i = 1'b0;
    logic       crt_vsync_o;
    logic       panel_frame_o;
    logic       fit_err_o;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    chk_en = 0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0, m_in = 0, m_err = 0;
    int s_nd = 0, s_st = 0, s_wd = 0, s_cp = 0, s_fp = 0, s_pas = 0;
    logic e_crt = 1'b1, e_pnl = 1'b1, e_err = 1'b0;

    always #5 clk = ~clk;

    vsync_pulse_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_stb_i    (line_stb_i),
        .vnd_start_i   (vnd_start_i),
        .nd_lines_i    (nd_lines_i),
        .sync_start_i  (sync_start_i),
        .sync_width_i  (sync_width_i),
        .crt_pol_i     (crt_pol_i),
        .frame_pol_i   (frame_pol_i),
        .passive_i     (passive_i),
        .crt_vsync_o   (crt_vsync_o),
        .panel_frame_o (panel_frame_o),
        .fit_err_o     (fit_err_o)
    );

    // Behavioural model: outputs lag the line state by one clock (R10).
    always @(posedge clk) begin
        bit act_c, act_p, lvl_p;
        chk_en <= 1'b1;
        if (!rst_n) begin
            m_cnt = 0; m_in = 0; m_err = 0;
            s_nd = 0; s_st = 0; s_wd = 0; s_cp = 0; s_fp = 0; s_pas = 0;
            e_crt = 1'b1; e_pnl = 1'b1;
        end else begin
            act_c = (m_in != 0) && (m_cnt >= s_st + 1) && (m_cnt <= s_st + s_wd + 1);
            act_p = (s_pas != 0) ? ((m_in != 0) && m_cnt == 0) : act_c;
            lvl_p = (s_pas != 0) ? (s_fp == 0) : (s_fp != 0);
            e_crt = act_c ? (s_cp != 0) : (s_cp == 0);
            e_pnl = act_p ? lvl_p : !lvl_p;
            if (line_stb_i) begin
                if (vnd_start_i) begin
                    s_nd = int'(nd_lines_i); s_st = int'(sync_start_i);
                    s_wd = int'(sync_width_i); s_cp = int'(crt_pol_i);
                    s_fp = int'(frame_pol_i); s_pas = int'(passive_i);
                    m_in = 1; m_cnt = 0;
                    if (s_st + 1 + s_wd + 1 > s_nd + 1) m_err = 1;
                end else if (m_in != 0) begin
                    if (m_cnt == s_nd) m_in = 0;
                    else m_cnt = m_cnt + 1;
                end
            end
        end
        e_err = (m_err != 0);
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    // Every-clock comparison against the model, tagged with the scenario requirement.
    always @(negedge clk) begin
        cyc++;
        if (chk_en) begin
            check(tag, "crt_vsync_o", crt_vsync_o, e_crt);
            check(tag, "panel_frame_o", panel_frame_o, e_pnl);
            check(tag, "fit_err_o", fit_err_o, e_err);
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic one_line(input bit first_nd);
        @(negedge clk);
        line_stb_i  = 1'b1;
        vnd_start_i = first_nd;
        @(negedge clk);
        line_stb_i  = 1'b0;
        vnd_start_i = 1'b0;
        repeat (LINE_CYC - 2) @(negedge clk);
    endtask

    // One frame: display lines, then nd+1 non-display lines; settings are
    // inverted halfway through the non-display part (R2) and restored after.
    task automatic frame(input int nd, input int st, input int wd, input int cp,
                         input int fp, input int pas, input string t);
        tag = t;
        nd_lines_i   = 6'(nd);
        sync_start_i = 6'(st);
        sync_width_i = 3'(wd);
        crt_pol_i    = 1'(cp);
        frame_pol_i  = 1'(fp);
        passive_i    = 1'(pas);
        for (int i = 0; i < DISP; i++) one_line(1'b0);
        for (int l = 0; l <= nd; l++) begin
            if (l == (nd + 1) / 2) begin
                nd_lines_i   = ~nd_lines_i;
                sync_start_i = ~sync_start_i;
                sync_width_i = ~sync_width_i;
                crt_pol_i    = ~crt_pol_i;
                frame_pol_i  = ~frame_pol_i;
                passive_i    = ~passive_i;
            end
            one_line(l == 0);
        end
        nd_lines_i   = 6'(nd);
        sync_start_i = 6'(st);
        sync_width_i = 3'(wd);
        crt_pol_i    = 1'(cp);
        frame_pol_i  = 1'(fp);
        passive_i    = 1'(pas);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset levels
        check("R1", "reset crt", crt_vsync_o, 1'b1);
        check("R1", "reset panel", panel_frame_o, 1'b1);
        check("R1", "reset err", fit_err_o, 1'b0);
        rst_n = 1'b1;
        // R3 R4 R5 R6 R10: active-matrix, active-high
        frame(15, 3, 2, 1, 1, 0, "R3");
        frame(15, 3, 2, 1, 1, 0, "R6");
        // R5: active-low, minimal start and width
        frame(10, 0, 0, 0, 0, 0, "R5");
        // R4: full width
        frame(20, 5, 7, 1, 0, 0, "R4");
        frame(63, 40, 7, 0, 1, 0, "R4");
        check("R9", "no error on fitting settings", fit_err_o, 1'b0);
        // R7: passive panel, both polarity bit values, start/width ignored
        frame(12, 6, 3, 1, 1, 1, "R7");
        frame(12, 0, 7, 0, 0, 1, "R7");
        frame(3, 20, 5, 1, 0, 1, "R7");
        // R8 R9: pulse truncated at end of non-display, error set
        frame(5, 3, 3, 1, 1, 0, "R8");
        check("R9", "error set on overflow", fit_err_o, 1'b1);
        frame(15, 3, 2, 1, 1, 0, "R9");
        check("R9", "error sticky", fit_err_o, 1'b1);
        // R3 R8: largest start never lands inside any non-display period
        frame(63, 63, 0, 1, 1, 0, "R3");
        // R2: boundary-only update with back-to-back frames of differing settings
        frame(8, 1, 1, 0, 1, 0, "R2");
        frame(9, 2, 3, 1, 0, 0, "R2");
        // R1: reset again clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        tag = "R1";
        repeat (2) @(negedge clk);
        check("R1", "err cleared by reset", fit_err_o, 1'b0);
        check("R1", "crt idle after reset", crt_vsync_o, 1'b1);
        rst_n = 1'b1;
        frame(7, 2, 1, 0, 0, 0, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule